// File: doc/BRIEF.md
# Interrupt cause collector with one wired output

This block gathers a vector of interrupt source lines into a sticky cause register and raises one wired interrupt line toward a parent interrupt controller. Software reaches the block over a simple register port: address, write enable, write data and combinational read data. It has four registers: the pending causes, a write-only port that raises causes, a per-source mask, and a control word.

Every source line passes through a synchronizer before it is used. One control bit selects how all sources are sensed, and it applies to every source at once. In level mode a high input sets its cause bit on every cycle. In edge mode only a 0-to-1 change sets it. Software acknowledges a cause by writing 0 to that bit position of the cause register. It can raise a cause again on purpose by writing 1s to the set port. One other control bit keeps the mask of a message-signalled path that is not built here. It is only stored and read back.

The sensing configuration is a two-state machine with the states CFG_LEVEL and CFG_EDGE. A control write with bit 3 set takes it to CFG_EDGE, and a control write with bit 3 clear takes it to CFG_LEVEL. Each source also has a line tracker with the states SRC_LOW and SRC_HIGH. The input going high is the "rise" transition and the input going low is the "fall" transition. In edge mode a cause bit is set only when the tracker is in SRC_LOW and sees a high input.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the mask register reads all ones, the control register reads 0, and the interrupt output is low.
- R2: Byte offsets: cause at 0x00, set port at 0x08, mask at 0x10, control at 0x28. Mask reads back what was written. Control keeps only bit 3 (edge sensing) and bit 5 (message-path mask); its other bits read 0. The set port and unmapped offsets read 0, and writes to unmapped offsets change nothing.
- R3: The interrupt output is high exactly while some cause bit is 1 and the mask bit at the same position is 0. A mask bit of 1 disables its source.
- R4: With control bit 3 at 0 (level), a high source sets its cause bit on every cycle. The bit appears in the cause register three clock edges after the input changes: two synchronizer stages, then the cause register. A clearing write does not take effect while the input stays high.
- R5: With control bit 3 at 1 (edge), a cause bit is set once per 0-to-1 change of the synchronized input. Once cleared, it stays clear while the input remains high, and it is set again on the next rise.
- R6: Writing a word to the set port sets every cause bit whose written bit is 1 and leaves the other cause bits unchanged.
- R7: Writing to the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. Writing 0 clears every pending cause.
- R8: When a hardware set and a clearing write hit the same cause bit in the same cycle, the bit ends up set. Other bits in the same write are still cleared.
- R9: The sensing mode applies to all sources together and takes effect on the cycle after the control write. Switching to level mode while inputs are held high sets their causes on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Asynchronous interrupt source lines |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data for bus_addr, combinational |
| irq_o | output | 1 | Wired interrupt to the parent controller |

## Verification
A source change reaches the cause register on the third rising edge after it is driven. The bench therefore checks cause two edges after the change, when it must still be clear, and again on the third. Register writes take effect on the single edge that samples the strobe, and reads and the interrupt output are combinational. Each check therefore samples on the falling edge that follows the write. For the set-versus-clear race, the clearing write is placed so that its strobe is sampled on exactly the third edge after the source rises, which is the edge where the hardware set arrives.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // register byte offsets
    localparam int unsigned OFS_CAUSE = 'h00;
    localparam int unsigned OFS_SETC  = 'h08;
    localparam int unsigned OFS_MASK  = 'h10;
    localparam int unsigned OFS_CTRL  = 'h28;

    // control word bit positions
    localparam int unsigned CTRL_EDGE_BIT = 3;
    localparam int unsigned CTRL_MSGM_BIT = 5;

    // global sensing configuration
    typedef enum logic {
        CFG_LEVEL = 1'b0,
        CFG_EDGE  = 1'b1
    } sense_cfg_e;

    // per-source line tracker
    typedef enum logic {
        SRC_LOW  = 1'b0,
        SRC_HIGH = 1'b1
    } line_st_e;

    // decoded register select
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_SETC,
        SEL_MASK,
        SEL_CTRL
    } reg_sel_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= async_i;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else begin
                    stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[LAST];

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sense_cfg_e   cfg,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] hw_set_o
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_src
            line_st_e st_q;
            line_st_e st_d;

            // state transition: rise / fall
            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    SRC_LOW:  if (lvl_i[g])  st_d = SRC_HIGH;
                    SRC_HIGH: if (!lvl_i[g]) st_d = SRC_LOW;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= SRC_LOW;
                end else begin
                    st_q <= st_d;
                end
            end

            // output decode
            always_comb begin
                unique case (cfg)
                    CFG_LEVEL: hw_set_o[g] = lvl_i[g];
                    CFG_EDGE:  hw_set_o[g] = (st_q == SRC_LOW) && lvl_i[g];
                endcase
            end
        end
    endgenerate

    // R5
    edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_EDGE && $past(cfg) == CFG_EDGE) |-> ((hw_set_o & $past(hw_set_o)) == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      hw_set,
    output sense_cfg_e        cfg_o,
    output logic              irq_o
);

    logic [W-1:0] cause_q, cause_d;
    logic [W-1:0] mask_q;
    logic         msgm_q;
    sense_cfg_e   cfg_q, cfg_d;
    reg_sel_e     sel;
    logic [W-1:0] keep_vec;
    logic [W-1:0] sw_set;

    // address decode
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
        if (addr == ADDR_W'(OFS_SETC))  sel = SEL_SETC;
        if (addr == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
        if (addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    end

    // sensing configuration machine: CFG_LEVEL <-> CFG_EDGE on control writes
    always_comb begin
        cfg_d = cfg_q;
        unique case (cfg_q)
            CFG_LEVEL: if (we && sel == SEL_CTRL && wdata[CTRL_EDGE_BIT])  cfg_d = CFG_EDGE;
            CFG_EDGE:  if (we && sel == SEL_CTRL && !wdata[CTRL_EDGE_BIT]) cfg_d = CFG_LEVEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_LEVEL;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // cause update: set sources win over the clearing write
    always_comb begin
        keep_vec = (we && sel == SEL_CAUSE) ? wdata : '1;
        sw_set   = (we && sel == SEL_SETC)  ? wdata : '0;
        cause_d  = (cause_q & keep_vec) | hw_set | sw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '1;
            msgm_q  <= 1'b0;
        end else begin
            cause_q <= cause_d;
            if (we && sel == SEL_MASK) mask_q <= wdata;
            if (we && sel == SEL_CTRL) msgm_q <= wdata[CTRL_MSGM_BIT];
        end
    end

    // read mux and outputs
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CAUSE: rdata = cause_q;
            SEL_MASK:  rdata = mask_q;
            SEL_CTRL: begin
                rdata[CTRL_EDGE_BIT] = (cfg_q == CFG_EDGE);
                rdata[CTRL_MSGM_BIT] = msgm_q;
            end
            SEL_SETC, SEL_NONE: rdata = '0;
        endcase
    end

    assign irq_o = |(cause_q & ~mask_q);
    assign cfg_o = cfg_q;

    // R6
    setc_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_SETC) |=> ((cause_q & $past(wdata)) == $past(wdata)));

    // R7
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_CAUSE && hw_set == '0) |=> (cause_q == ($past(cause_q) & $past(wdata))));

    // R8
    hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((cause_q & $past(hw_set)) == $past(hw_set)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set == '0 && !(we && sel == SEL_SETC)) |=> ((cause_q & ~$past(cause_q)) == '0));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_MASK) |=> (mask_q == $past(wdata)));

    // R9
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_CTRL) |=> ((cfg_q == CFG_EDGE) == $past(wdata[CTRL_EDGE_BIT])));

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC        = 32,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_o
);

    logic [NSRC-1:0] src_sync;
    logic [NSRC-1:0] hw_set;
    sense_cfg_e      cfg;

    irqc_sync #(
        .W      (NSRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irqc_detect #(
        .W (NSRC)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .lvl_i    (src_sync),
        .hw_set_o (hw_set)
    );

    irqc_regs #(
        .W      (NSRC),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .hw_set (hw_set),
        .cfg_o  (cfg),
        .irq_o  (irq_o)
    );

endmodule

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;

    localparam int N = 32;
    localparam logic [5:0] A_CAUSE = 6'h00;
    localparam logic [5:0] A_SETC  = 6'h08;
    localparam logic [5:0] A_MASK  = 6'h10;
    localparam logic [5:0] A_CTRL  = 6'h28;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] src;
    logic [5:0]   addr;
    logic         we;
    logic [N-1:0] wdata;
    logic [N-1:0] rdata;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irq_cause_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [N-1:0] v;
        rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CAUSE, v); chk("R1 cause", v, '0);
        rd(A_MASK, v);  chk("R1 mask", v, '1);
        rd(A_CTRL, v);  chk("R1 ctrl", v, '0);
        chk("R1 irq", N'(irq), '0);

        // R2 register map
        wr(A_CTRL, '1);
        rd(A_CTRL, v); chk("R2 ctrl keeps bits 3,5", v, 32'h28);
        wr(A_CTRL, 32'h20);
        rd(A_CTRL, v); chk("R2 ctrl level", v, 32'h20);
        wr(A_MASK, 32'h1234_5678);
        rd(A_MASK, v); chk("R2 mask readback", v, 32'h1234_5678);
        wr(6'h04, '1);
        rd(6'h04, v);  chk("R2 unmapped read", v, '0);
        rd(A_CAUSE, v); chk("R2 unmapped write no cause", v, '0);
        rd(A_MASK, v);  chk("R2 unmapped write no mask", v, 32'h1234_5678);

        // R6 / R7 / R3 software set and clear
        wr(A_MASK, '1);
        wr(A_SETC, 32'hA5A5_0F0F);
        rd(A_SETC, v);  chk("R2 set port reads 0", v, '0);
        rd(A_CAUSE, v); chk("R6 set port", v, 32'hA5A5_0F0F);
        chk("R3 all masked", N'(irq), '0);
        wr(A_SETC, 32'h0000_0030);
        rd(A_CAUSE, v); chk("R6 set keeps others", v, 32'hA5A5_0F3F);
        wr(A_CAUSE, 32'hFFFF_0000);
        rd(A_CAUSE, v); chk("R7 ones keep zeros clear", v, 32'hA5A5_0000);
        wr(A_MASK, ~(32'h1 << 24));
        chk("R3 unmasked pending", N'(irq), 1);
        wr(A_MASK, ~(32'h1 << 25));
        chk("R3 unmasked idle bit", N'(irq), 0);
        wr(A_CAUSE, '0);
        rd(A_CAUSE, v); chk("R7 clear all", v, '0);

        // R4 level sweep
        wr(A_MASK, '0);
        wr(A_CTRL, 32'h20);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); src = N'(1) << i;
            repeat (2) @(negedge clk);
            rd(A_CAUSE, v); chk("R4 not before third edge", v, '0);
            @(negedge clk);
            rd(A_CAUSE, v); chk("R4 level set", v, N'(1) << i);
            chk("R3 irq up", N'(irq), 1);
            wr(A_MASK, N'(1) << i);
            chk("R3 masked", N'(irq), 0);
            wr(A_MASK, '0);
            wr(A_CAUSE, '0);
            rd(A_CAUSE, v); chk("R4 clear held while high", v, N'(1) << i);
            src = '0;
            repeat (3) @(negedge clk);
            wr(A_CAUSE, '0);
            rd(A_CAUSE, v); chk("R4 clear after low", v, '0);
        end

        // R5 edge sweep
        wr(A_CTRL, 32'h28);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); src = N'(1) << i;
            repeat (3) @(negedge clk);
            rd(A_CAUSE, v); chk("R5 edge set", v, N'(1) << i);
            wr(A_CAUSE, '0);
            repeat (4) @(negedge clk);
            rd(A_CAUSE, v); chk("R5 stays clear while high", v, '0);
            src = '0;
            repeat (3) @(negedge clk);
            rd(A_CAUSE, v); chk("R5 fall sets nothing", v, '0);
            src = N'(1) << i;
            repeat (3) @(negedge clk);
            rd(A_CAUSE, v); chk("R5 second rise", v, N'(1) << i);
            src = '0;
            repeat (3) @(negedge clk);
            wr(A_CAUSE, '0);
        end

        // R8 set beats clear in the same cycle
        wr(A_SETC, 32'h80);
        @(negedge clk); src = 32'h8;
        @(negedge clk);
        wr(A_CAUSE, '0);
        rd(A_CAUSE, v); chk("R8 set wins, other cleared", v, 32'h8);
        src = '0;
        repeat (3) @(negedge clk);
        wr(A_CAUSE, '0);

        // R9 global mode
        @(negedge clk); src = '1;
        repeat (3) @(negedge clk);
        rd(A_CAUSE, v); chk("R9 edge all sources", v, '1);
        wr(A_CAUSE, '0);
        rd(A_CAUSE, v); chk("R9 edge clear holds", v, '0);
        wr(A_CTRL, 32'h20);
        rd(A_CAUSE, v); chk("R9 not yet level", v, '0);
        @(negedge clk);
        rd(A_CAUSE, v); chk("R9 level refills all", v, '1);
        src = '0;
        repeat (3) @(negedge clk);
        wr(A_CAUSE, '0);
        rd(A_CAUSE, v); chk("R7 final clear", v, '0);
        chk("R3 final irq low", N'(irq), 0);

        report();
    end

endmodule